// File: doc/BRIEF.md
# Cache performance event selector

This unit sits beside an instruction cache and a data cache and chooses which of their activity signals reach two external timer/counters. Each cache supplies single-cycle strobes for things like misses, copybacks and prefetch outcomes. Each cache also supplies a level signal that stays high for as long as it is stalled.

A 32-bit read/write control register holds two 4-bit selector codes. Each code picks one event, and that event drives one count-enable output. Two different events can therefore be measured at once.

Stall cycles are split so that no cycle is counted twice. A cycle in which both caches are stalled belongs to the instruction cache only. Prefetch discards can be counted in two ways: every discard, or only the discards caused by a cache hit.

Top module: `cache_evt_sel`

## Requirements
- R1: Register bits [3:0] hold selector 1, which drives `cnt_en1`. Bits [7:4] hold selector 2, which drives `cnt_en2`. A write (`wr_en` high at a clock edge) loads these bits from `wr_data`, and `rd_data` shows them from the following cycle.
- R2: A write ignores bits [31:8] of `wr_data`, and `rd_data[31:8]` always reads 0.
- R3: Reset (`rst_n` low) clears the register to 0 and drives both count enables low.
- R4: The selector codes map to inputs as follows:
  - 1 selects `ic_miss`
  - 3 selects `dc_bank_conflict`
  - 4 selects `dc_rd_miss`
  - 5 selects `dc_wr_miss`
  - 7 selects `dc_copyback`
  - 8 selects `cb_full`
  - 9 selects `dc_wr_miss_busy`
  - 10 selects `dc_stream_miss`
  - 11 selects `pf_kept`
- R5: Code 2 counts every cycle with `ic_stall` high, whether or not `dc_stall` is also high.
- R6: Code 6 counts only cycles with `dc_stall` high and `ic_stall` low. Codes 2 and 6 therefore never count the same cycle.
- R7: Code 12 counts every cycle with `pf_discard` high. Code 13 counts only cycles with both `pf_discard` and `pf_discard_hit` high.
- R8: Codes 0, 14 and 15 never raise a count enable, whatever the inputs are doing.
- R9: A count enable is high in exactly the one cycle after the cycle in which its selected event was present.
- R10: Events present in the cycle of a register write are still judged under the old selection. From the next cycle on, only the new selection is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register readback |
| ic_miss | input | 1 | Instruction-cache miss strobe |
| ic_stall | input | 1 | Instruction cache stalled (level) |
| dc_bank_conflict | input | 1 | Data-cache bank conflict strobe |
| dc_rd_miss | input | 1 | Data-cache read miss strobe |
| dc_wr_miss | input | 1 | Data-cache write miss strobe |
| dc_stall | input | 1 | Data cache stalled (level) |
| dc_copyback | input | 1 | Data-cache copyback to memory strobe |
| cb_full | input | 1 | Copyback buffer full |
| dc_wr_miss_busy | input | 1 | Write miss with every fetch unit busy |
| dc_stream_miss | input | 1 | Data-cache stream miss strobe |
| pf_kept | input | 1 | Prefetch started and not discarded |
| pf_discard | input | 1 | Prefetch discarded, for any reason |
| pf_discard_hit | input | 1 | Discard reason was a cache hit (qualifies `pf_discard`) |
| cnt_en1 | output | 1 | Count enable for timer 1 |
| cnt_en2 | output | 1 | Count enable for timer 2 |

## Verification
Every count enable is due one clock after the cycle in which its event was applied. The bench therefore drives inputs on a falling edge and reads the outputs on the following falling edge, so that exactly one rising edge falls in between. Readback of a write is due on that same falling edge, because the register loads at the rising edge between the two.

For the selection switch, the bench reads the output twice. The first read is one clock after the write cycle, and it must still follow the old code. The second read comes after the next event cycle, and it must follow only the new code.

// File: rtl/cache_evt_sel.sv
module cache_evt_sel #(
  parameter int REG_W = 32,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ic_miss,
  input  logic             ic_stall,
  input  logic             dc_bank_conflict,
  input  logic             dc_rd_miss,
  input  logic             dc_wr_miss,
  input  logic             dc_stall,
  input  logic             dc_copyback,
  input  logic             cb_full,
  input  logic             dc_wr_miss_busy,
  input  logic             dc_stream_miss,
  input  logic             pf_kept,
  input  logic             pf_discard,
  input  logic             pf_discard_hit,
  output logic             cnt_en1,
  output logic             cnt_en2
);
  localparam int NCH    = 2;
  localparam int NCODE  = 1 << SEL_W;
  localparam int USED_W = NCH * SEL_W;
  localparam logic [REG_W-1:0] WMASK = {{(REG_W-USED_W){1'b0}}, {USED_W{1'b1}}};

  logic [REG_W-1:0] ctrl_q;
  logic [NCODE-1:0] ev;
  logic [NCH-1:0]   en_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data & WMASK;

  assign rd_data = ctrl_q;

  always_comb begin
    ev     = '0;
    ev[1]  = ic_miss;
    ev[2]  = ic_stall;
    ev[3]  = dc_bank_conflict;
    ev[4]  = dc_rd_miss;
    ev[5]  = dc_wr_miss;
    ev[6]  = dc_stall & ~ic_stall;
    ev[7]  = dc_copyback;
    ev[8]  = cb_full;
    ev[9]  = dc_wr_miss_busy;
    ev[10] = dc_stream_miss;
    ev[11] = pf_kept;
    ev[12] = pf_discard;
    ev[13] = pf_discard & pf_discard_hit;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) en_q[i] <= 1'b0;
      else        en_q[i] <= ev[ctrl_q[i*SEL_W +: SEL_W]];
  end

  assign cnt_en1 = en_q[0];
  assign cnt_en2 = en_q[1];
endmodule

module cache_evt_sel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        ic_stall,
  input logic        cnt_en1,
  input logic        cnt_en2
);
  a_r3_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (rd_data == 32'd0 && !cnt_en1 && !cnt_en2));

  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[7:0] == $past(wr_data[7:0]));

  a_r2_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[31:8] == 24'd0);

  a_r5_ic_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] == 4'd2) |=> cnt_en1 == $past(ic_stall));

  a_r6_stall_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] == 4'd2 && rd_data[7:4] == 4'd6) |=> !(cnt_en1 && cnt_en2));

  a_r7_hit_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] == 4'd13 && rd_data[7:4] == 4'd12) |=> (!cnt_en1 || cnt_en2));

  a_r8_silent_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[3:0] == 4'd0 || rd_data[3:0] >= 4'd14) |=> !cnt_en1);
endmodule

bind cache_evt_sel cache_evt_sel_chk u_chk (.*);

// File: tb/cache_evt_sel_test.sv
`timescale 1ns/1ps
module cache_evt_sel_test;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [13:1] pin = 0;
  logic cnt_en1, cnt_en2;
  int vecs = 0, errs = 0;

  always #2.5 clk = ~clk;

  cache_evt_sel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ic_miss(pin[1]), .ic_stall(pin[2]), .dc_bank_conflict(pin[3]),
    .dc_rd_miss(pin[4]), .dc_wr_miss(pin[5]), .dc_stall(pin[6]),
    .dc_copyback(pin[7]), .cb_full(pin[8]), .dc_wr_miss_busy(pin[9]),
    .dc_stream_miss(pin[10]), .pf_kept(pin[11]), .pf_discard(pin[12]),
    .pf_discard_hit(pin[13]), .cnt_en1(cnt_en1), .cnt_en2(cnt_en2));

  task automatic chk(input string req, input logic [31:0] act, exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d; pin = 0;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic cyc(input logic [13:1] p, input logic e1, e2, input string req);
    @(negedge clk); pin = p;
    @(negedge clk); pin = 0;
    chk(req, {31'd0, cnt_en1}, {31'd0, e1});
    chk(req, {31'd0, cnt_en2}, {31'd0, e2});
  endtask

  task automatic t_reset;
    rst_n = 0; pin = '1;
    repeat (3) @(negedge clk);
    chk("R3 rd_data", rd_data, 0);
    chk("R3 cnt_en1", {31'd0, cnt_en1}, 0);
    chk("R3 cnt_en2", {31'd0, cnt_en2}, 0);
    pin = 0; rst_n = 1;
  endtask

  task automatic t_layout;
    wr(32'hFFFF_FF5A);
    chk("R1 R2 readback", rd_data, 32'h0000_005A);
    cyc(13'b1 << 4, 0, 1, "R1 sel2=5 drives cnt_en2 only");
    cyc(13'b1 << 9, 1, 0, "R1 sel1=10 drives cnt_en1 only");
    wr(32'h1234_5600);
    chk("R2 upper ignored", rd_data, 0);
  endtask

  task automatic t_direct;
    int codes[9] = '{1, 3, 4, 5, 7, 8, 9, 10, 11};
    foreach (codes[k]) begin
      wr(codes[k]);
      cyc(13'b1 << (codes[k] - 1), 1, 0, "R4 selected event");
      cyc(~(13'b1 << (codes[k] - 1)) & 13'h0FFF, 0, 0, "R4 other events");
      cyc(0, 0, 0, "R9 one-cycle pulse");
    end
  endtask

  task automatic t_stall;
    wr(32'h62);
    cyc(0, 0, 0, "R5 R6 no stall");
    cyc(13'b1 << 1, 1, 0, "R5 ic only");
    cyc(13'b1 << 5, 0, 1, "R6 dc only");
    cyc((13'b1 << 1) | (13'b1 << 5), 1, 0, "R6 both stall -> ic");
  endtask

  task automatic t_prefetch;
    wr(32'hCD);
    cyc(13'b1 << 11, 0, 1, "R7 discard no hit");
    cyc((13'b1 << 11) | (13'b1 << 12), 1, 1, "R7 discard on hit");
    cyc(13'b1 << 12, 0, 0, "R7 hit without discard");
  endtask

  task automatic t_silent;
    wr(32'hE0); cyc(13'h1FFF, 0, 0, "R8 codes 0,14");
    wr(32'h0F); cyc(13'h1FFF, 0, 0, "R8 codes 15,0");
    wr(32'hEF); cyc(13'h1FFF, 0, 0, "R8 codes 15,14");
  endtask

  task automatic t_switch;
    wr(32'h01);
    @(negedge clk); wr_en = 1; wr_data = 32'h04; pin = 13'b1;
    @(negedge clk); wr_en = 0;
    chk("R10 write-cycle event uses old code", {31'd0, cnt_en1}, 1);
    pin = 13'b1;
    @(negedge clk); pin = 0;
    chk("R10 old event ignored after switch", {31'd0, cnt_en1}, 0);
    cyc(13'b1 << 3, 1, 0, "R10 new event counted");
  endtask

  initial begin
    fork
      begin
        t_reset; t_layout; t_direct; t_stall; t_prefetch; t_silent; t_switch;
      end
      begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule